// File: doc/BRIEF.md
# Harvest/Battery Supply Mode Controller

This controller decides, every clock cycle, where a self-powered sensor draws its supply and what the sensor is doing. There are two choices. The supply comes either from the battery or from the storage capacitor that the on-chip harvester charges. The sensor is either imaging or harvesting. The analog comparators that watch the storage node arrive as three single-bit flags:
- storage above battery by one hysteresis step,
- storage below battery,
- storage above the bleed (skim) level.

Each flag passes through a two-flop synchroniser before the controller uses it.

The supply hand-off uses two thresholds. The controller moves to the harvested node only after the storage voltage clears the upper threshold. It returns to the battery only when the storage node falls to the lower threshold. Between the two thresholds it keeps its current choice. The two switch enables never overlap, and one dead cycle separates them.

In autonomous mode the self-powered status alone picks the operating mode. Running on the battery means the sensor harvests, and running self-powered means it images, so the sensor settles into a duty cycle. A forcing input pins the supply to the battery during start-up. A windowed counter reports how many cycles of each window were spent self-powered.

Top module: `supply_mode_ctrl`

## Requirements
- R1: During and right after reset, `sel_batt`=1, `sel_harv`=0, `self_powered`=0, `harvest_mode`=1, `img_en`=0, `skim_en`=0, `sp_count`=0 and `count_valid`=0.
- R2: On the battery, when `stor_above_hyst` goes high, both selects are low after the third rising edge. `sel_harv` and `self_powered` are 1 after the fourth edge.
- R3: While neither `stor_above_hyst` nor `stor_below_batt` is high, the supply selection does not change. This holds whichever supply is active.
- R4: On the harvested supply, when `stor_below_batt` goes high, both selects are low after the third edge and `sel_batt` is 1 after the fourth. This also applies while the sensor is imaging.
- R5: `sel_batt` and `sel_harv` are never both 1. Every change between them passes through at least one cycle with both at 0.
- R6: When `harvest_mode` is 1, `img_en` is all zeros. Otherwise `img_en` equals `img_req` as sampled at the previous edge.
- R7: With `auto_mode_en`=1, `harvest_mode` is the inverse of `self_powered` one edge later. With `auto_mode_en`=0, `harvest_mode` follows `harvest_req` one edge later.
- R8: `skim_en` follows `stor_above_skim` three edges later, whichever supply is selected.
- R9: While `force_batt` is 1, `sel_harv` is 0 from the next edge and `sel_batt` is 1 one edge after that. No switch to the harvested supply occurs until `force_batt` drops.
- R10: When a window of `window_len` cycles ends, `count_valid` pulses for one cycle. `sp_count` then holds the number of cycles in that window during which `self_powered` was 1. A `window_len` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_batt | input | 1 | Start-up override that pins the supply to the battery |
| auto_mode_en | input | 1 | 1: self-powered status picks the mode; 0: `harvest_req` picks it |
| harvest_req | input | 1 | Manual request for harvesting mode |
| img_req | input | NUM_IMG | Requested imaging block enables |
| stor_above_hyst | input | 1 | Async flag: storage above battery plus hysteresis |
| stor_below_batt | input | 1 | Async flag: storage below battery |
| stor_above_skim | input | 1 | Async flag: storage above bleed threshold |
| window_len | input | CNT_W | Duty measurement window in cycles |
| sel_batt | output | 1 | Battery supply switch enable |
| sel_harv | output | 1 | Harvested supply switch enable |
| skim_en | output | 1 | Bleed enable |
| harvest_mode | output | 1 | Harvesting mode; imaging blocks are off |
| img_en | output | NUM_IMG | Gated imaging block enables |
| self_powered | output | 1 | Running from harvested supply |
| sp_count | output | CNT_W | Self-powered cycles in the last window |
| count_valid | output | 1 | One-cycle pulse when `sp_count` updates |

## Verification
The assertions take some things for granted about the inputs:
- `force_batt`, `auto_mode_en`, `harvest_req`, `img_req` and `window_len` are synchronous to `clk`. They are checked without any synchroniser latency.
- The comparator flags describe a physically consistent storage voltage, so "above plus hysteresis" and "below battery" are never high together.

The stimulus changes every input half a cycle away from the rising edge. It never raises the two opposing comparator flags at the same time. It holds each flag level for longer than the synchroniser depth, which keeps the fixed-latency checks meaningful.

// File: rtl/supply_pkg.sv
package supply_pkg;
  typedef enum logic [1:0] {
    SUP_BATT    = 2'd0,
    SUP_TO_HARV = 2'd1,
    SUP_HARV    = 2'd2,
    SUP_TO_BATT = 2'd3
  } sup_state_t;

  localparam int unsigned FLAG_N    = 3;
  localparam int unsigned FLAG_HYST = 0;
  localparam int unsigned FLAG_LOW  = 1;
  localparam int unsigned FLAG_SKIM = 2;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign sync_out[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/supply_fsm.sv
module supply_fsm
  import supply_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic force_batt,
  input  logic go_harv,
  input  logic go_batt,
  output logic sel_batt,
  output logic sel_harv,
  output logic self_powered
);
  sup_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      SUP_BATT:    if (go_harv && !force_batt) state_nx = SUP_TO_HARV;
      SUP_TO_HARV: state_nx = force_batt ? SUP_BATT : SUP_HARV;
      SUP_HARV:    if (go_batt || force_batt) state_nx = SUP_TO_BATT;
      SUP_TO_BATT: state_nx = SUP_BATT;
      default:     state_nx = SUP_BATT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SUP_BATT;
      sel_batt     <= 1'b1;
      sel_harv     <= 1'b0;
      self_powered <= 1'b0;
    end else begin
      state        <= state_nx;
      sel_batt     <= (state_nx == SUP_BATT);
      sel_harv     <= (state_nx == SUP_HARV);
      self_powered <= (state_nx == SUP_HARV);
    end
  end
endmodule

// File: rtl/duty_counter.sv
module duty_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] window_len,
  output logic [CNT_W-1:0] count,
  output logic             valid
);
  logic [CNT_W-1:0] cyc, acc, acc_nx;
  logic [CNT_W:0]   cyc_inc;
  logic             last;

  assign cyc_inc = {1'b0, cyc} + {{CNT_W{1'b0}}, 1'b1};
  assign last    = (cyc_inc >= {1'b0, window_len});
  assign acc_nx  = acc + {{(CNT_W-1){1'b0}}, active};

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= '0;
      acc   <= '0;
      count <= '0;
      valid <= 1'b0;
    end else begin
      valid <= last;
      if (last) begin
        cyc   <= '0;
        acc   <= '0;
        count <= acc_nx;
      end else begin
        cyc <= cyc_inc[CNT_W-1:0];
        acc <= acc_nx;
      end
    end
  end
endmodule

// File: rtl/supply_mode_ctrl.sv
module supply_mode_ctrl
  import supply_pkg::*;
#(
  parameter int unsigned NUM_IMG     = 3,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               force_batt,
  input  logic               auto_mode_en,
  input  logic               harvest_req,
  input  logic [NUM_IMG-1:0] img_req,
  input  logic               stor_above_hyst,
  input  logic               stor_below_batt,
  input  logic               stor_above_skim,
  input  logic [CNT_W-1:0]   window_len,
  output logic               sel_batt,
  output logic               sel_harv,
  output logic               skim_en,
  output logic               harvest_mode,
  output logic [NUM_IMG-1:0] img_en,
  output logic               self_powered,
  output logic [CNT_W-1:0]   sp_count,
  output logic               count_valid
);
  logic [FLAG_N-1:0] raw_flags, s_flags;
  logic              harvest_nx;

  assign raw_flags[FLAG_HYST] = stor_above_hyst;
  assign raw_flags[FLAG_LOW]  = stor_below_batt;
  assign raw_flags[FLAG_SKIM] = stor_above_skim;

  flag_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_flags),
    .sync_out (s_flags)
  );

  supply_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .force_batt   (force_batt),
    .go_harv      (s_flags[FLAG_HYST]),
    .go_batt      (s_flags[FLAG_LOW]),
    .sel_batt     (sel_batt),
    .sel_harv     (sel_harv),
    .self_powered (self_powered)
  );

  assign harvest_nx = auto_mode_en ? !self_powered : harvest_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      harvest_mode <= 1'b1;
      img_en       <= '0;
      skim_en      <= 1'b0;
    end else begin
      harvest_mode <= harvest_nx;
      img_en       <= harvest_nx ? '0 : img_req;
      skim_en      <= s_flags[FLAG_SKIM];
    end
  end

  duty_counter #(.CNT_W(CNT_W)) u_duty (
    .clk        (clk),
    .rst        (rst),
    .active     (self_powered),
    .window_len (window_len),
    .count      (sp_count),
    .valid      (count_valid)
  );
endmodule

// File: rtl/supply_mode_chk.sv
module supply_mode_chk #(
  parameter int unsigned NUM_IMG = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               force_batt,
  input logic               auto_mode_en,
  input logic               sel_batt,
  input logic               sel_harv,
  input logic               self_powered,
  input logic               harvest_mode,
  input logic [NUM_IMG-1:0] img_en
);
  // R5: selects never overlap
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(sel_batt && sel_harv));

  // R5: harvested switch closes only after a dead cycle
  p_gap_harv_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_harv) |-> $past(!sel_batt));

  // R5: battery switch closes only after a dead cycle
  p_gap_batt_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_batt) |-> $past(!sel_harv));

  // R6: imaging blocks off while harvesting
  p_img_off_r6: assert property (@(posedge clk) disable iff (rst)
    harvest_mode |-> (img_en == '0));

  // R7: autonomous mode tracks the inverse of self-powered status
  p_auto_mode_r7: assert property (@(posedge clk) disable iff (rst)
    $past(auto_mode_en) |-> (harvest_mode == !$past(self_powered)));

  // R9: start-up override opens the harvested switch next cycle
  p_force_r9: assert property (@(posedge clk) disable iff (rst)
    force_batt |=> !sel_harv);
endmodule

bind supply_mode_ctrl supply_mode_chk #(.NUM_IMG(NUM_IMG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .force_batt   (force_batt),
  .auto_mode_en (auto_mode_en),
  .sel_batt     (sel_batt),
  .sel_harv     (sel_harv),
  .self_powered (self_powered),
  .harvest_mode (harvest_mode),
  .img_en       (img_en)
);

// File: tb/tb_supply_mode_ctrl.sv
module tb_supply_mode_ctrl;
  localparam int unsigned NUM_IMG = 3;
  localparam int unsigned CNT_W   = 16;

  logic               clk = 1'b0;
  logic               rst;
  logic               force_batt, auto_mode_en, harvest_req;
  logic [NUM_IMG-1:0] img_req;
  logic               stor_above_hyst, stor_below_batt, stor_above_skim;
  logic [CNT_W-1:0]   window_len;
  logic               sel_batt, sel_harv, skim_en, harvest_mode, self_powered, count_valid;
  logic [NUM_IMG-1:0] img_en;
  logic [CNT_W-1:0]   sp_count;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  supply_mode_ctrl #(.NUM_IMG(NUM_IMG), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .force_batt(force_batt), .auto_mode_en(auto_mode_en),
    .harvest_req(harvest_req), .img_req(img_req),
    .stor_above_hyst(stor_above_hyst), .stor_below_batt(stor_below_batt),
    .stor_above_skim(stor_above_skim), .window_len(window_len),
    .sel_batt(sel_batt), .sel_harv(sel_harv), .skim_en(skim_en),
    .harvest_mode(harvest_mode), .img_en(img_en), .self_powered(self_powered),
    .sp_count(sp_count), .count_valid(count_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (count_valid) return;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; force_batt = 1'b0; auto_mode_en = 1'b0; harvest_req = 1'b1;
    img_req = 3'b101; stor_above_hyst = 1'b0; stor_below_batt = 1'b0;
    stor_above_skim = 1'b0; window_len = 16'd8;
    step(3);
    chk("R1 sel_batt in reset", sel_batt, 1);
    rst = 1'b0;
    step(1);
    chk("R1 sel_batt", sel_batt, 1);
    chk("R1 sel_harv", sel_harv, 0);
    chk("R1 self_powered", self_powered, 0);
    chk("R1 harvest_mode", harvest_mode, 1);
    chk("R1 img_en", img_en, 0);
    chk("R1 skim_en", skim_en, 0);
    chk("R1 sp_count", sp_count, 0);
    chk("R1 count_valid", count_valid, 0);
  endtask

  task automatic t_hold_battery();
    step(10);
    chk("R3 battery held, no flags", sel_batt, 1);
    stor_below_batt = 1'b1;
    step(6);
    chk("R3 battery held, low flag", sel_batt, 1);
    chk("R3 harvested off", sel_harv, 0);
    stor_below_batt = 1'b0;
    step(3);
  endtask

  task automatic t_manual_mode();
    harvest_req = 1'b0; img_req = 3'b101;
    step(1);
    chk("R7 manual imaging", harvest_mode, 0);
    chk("R6 img_en follows request", img_en, 3'b101);
    img_req = 3'b011;
    step(1);
    chk("R6 img_en new request", img_en, 3'b011);
    harvest_req = 1'b1;
    step(1);
    chk("R7 manual harvest", harvest_mode, 1);
    chk("R6 img_en gated", img_en, 0);
    harvest_req = 1'b0;
    step(1);
  endtask

  task automatic t_to_harvest();
    stor_above_hyst = 1'b1;
    step(2);
    chk("R2 before switch", sel_batt, 1);
    step(1);
    chk("R5 gap sel_batt", sel_batt, 0);
    chk("R5 gap sel_harv", sel_harv, 0);
    step(1);
    chk("R2 sel_harv", sel_harv, 1);
    chk("R2 self_powered", self_powered, 1);
    stor_above_hyst = 1'b0;
    step(10);
    chk("R3 harvested held", sel_harv, 1);
  endtask

  task automatic t_duty(input logic [CNT_W-1:0] len, input logic [CNT_W-1:0] exp, input string tag);
    window_len = len;
    wait_valid();
    wait_valid();
    chk({"R10 valid ", tag}, count_valid, 1);
    chk({"R10 count ", tag}, sp_count, exp);
    step(1);
    chk({"R10 pulse width ", tag}, count_valid, (len <= 1) ? 1 : 0);
  endtask

  task automatic t_back_battery();
    chk("R4 imaging before fallback", harvest_mode, 0);
    stor_below_batt = 1'b1;
    step(3);
    chk("R5 gap back sel_harv", sel_harv, 0);
    chk("R5 gap back sel_batt", sel_batt, 0);
    step(1);
    chk("R4 sel_batt", sel_batt, 1);
    chk("R4 self_powered", self_powered, 0);
    stor_below_batt = 1'b0;
    step(3);
  endtask

  task automatic t_auto();
    auto_mode_en = 1'b1; img_req = 3'b110;
    step(1);
    chk("R7 auto on battery harvests", harvest_mode, 1);
    chk("R6 auto gating", img_en, 0);
    stor_above_hyst = 1'b1;
    step(4);
    chk("R2 auto switch", sel_harv, 1);
    step(1);
    chk("R7 auto self-powered images", harvest_mode, 0);
    chk("R6 auto img_en", img_en, 3'b110);
    stor_above_hyst = 1'b0; stor_below_batt = 1'b1;
    step(4);
    chk("R4 auto fallback", sel_batt, 1);
    chk("R7 auto back to harvest", harvest_mode, 1);
    stor_below_batt = 1'b0; auto_mode_en = 1'b0;
    step(2);
  endtask

  task automatic t_skim();
    stor_above_skim = 1'b1;
    step(2);
    chk("R8 skim latency", skim_en, 0);
    step(1);
    chk("R8 skim on", skim_en, 1);
    chk("R8 skim on battery", sel_batt, 1);
    stor_above_skim = 1'b0;
    step(2);
    chk("R8 skim still on", skim_en, 1);
    step(1);
    chk("R8 skim off", skim_en, 0);
  endtask

  task automatic t_force();
    stor_above_hyst = 1'b1;
    step(4);
    chk("R2 before force", sel_harv, 1);
    force_batt = 1'b1;
    step(1);
    chk("R9 harvested off", sel_harv, 0);
    step(1);
    chk("R9 battery on", sel_batt, 1);
    step(10);
    chk("R9 held on battery", sel_batt, 1);
    chk("R9 harvested stays off", sel_harv, 0);
    force_batt = 1'b0;
    step(2);
    chk("R9 release resumes", sel_harv, 1);
    stor_above_hyst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_hold_battery();
    t_manual_mode();
    t_to_harvest();
    t_duty(16'd8, 16'd8, "self-powered");
    t_back_battery();
    t_duty(16'd5, 16'd0, "battery");
    t_auto();
    t_skim();
    t_force();
    t_duty(16'd0, 16'd1, "zero window");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule